// File: doc/BRIEF.md
# Stream Item Counter and Run Control

This block owns the run state of a single transfer stream and the number of data items that stream still has to move. Software programs an item count, a wrap mode and a small configuration field through a word-addressed register port. It then sets the run bit. Each completed item reported by the transfer engine lowers the count by one, and `req_ok` tells the engine whether a new item may be requested.

Hardware drops the run bit when the last item completes in one-shot mode, when the bus reports a transfer error, or when the FIFO threshold does not match the burst size. Each of these stops raises its own sticky event flag. Software clears a flag by writing 1 to that flag's bit in the clear register. In wrap mode the counter refills from the last programmed count when it runs out, and the stream keeps running. Count and configuration cannot be changed while the stream runs.

Register map (byte offsets, bits [3:2] select the register): 0x0 control (bit 0 run, bit 1 wrap mode, bits 7:2 configuration); 0x4 item count (bits 15:0, bits 31:16 read as zero); 0x8 event status; 0xC event clear (write 1 to clear). In the status and clear registers, bit 0 is item-count-exhausted, bit 1 is bus error and bit 2 is burst mismatch.

Top module: `xsc_stream_ctl`

## Requirements
- R1: After reset the run bit, wrap bit, configuration, count, reload value and all flags are 0, and `req_ok` is 0.
- R2: A write to the count register while stopped loads bits 15:0 into both the live count and the reload value. Reading the count register returns the count in bits 15:0 with bits 31:16 zero.
- R3: While running, writes to the count register and to the wrap and configuration bits of the control register are ignored.
- R4: Setting the run bit loads the live count from the reload value, and this includes every restart after a stop. `req_ok` is 1 exactly when running with a nonzero count.
- R5: While running with a nonzero count, each `item_done` pulse lowers the count by exactly one.
- R6: In one-shot mode (wrap bit 0), the item that takes the count to zero sets flag bit 0 in that same clock edge. It also clears the run bit, and the count stays 0.
- R7: In wrap mode (wrap bit 1), the item that would take the count to zero instead reloads it and sets flag bit 0, and the stream stays running.
- R8: While running with a count of 0, `item_done` has no effect, `req_ok` is 0, and the run bit stays 1.
- R9: `bus_err` while running clears the run bit, sets flag bit 1, and leaves the count unchanged.
- R10: `burst_mismatch` while running clears the run bit and sets flag bit 2.
- R11: A write that sets the run bit is refused while any flag is set, so the run bit stays 0.
- R12: When `bus_err` and the final `item_done` arrive in the same cycle, the error wins. Flag bit 1 sets, flag bit 0 does not, the count is not lowered, and the stream stops.
- R13: A write to the clear register clears only the flags whose bits are 1 in the write data. The other flags keep their values.
- R14: Writing 0 to the run bit while running stops the stream and keeps the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| item_done | input | 1 | One data item completed this cycle |
| bus_err | input | 1 | Bus transfer error this cycle |
| burst_mismatch | input | 1 | FIFO threshold incompatible with burst size |
| enabled | output | 1 | Live run state |
| remaining | output | 16 | Items still to move |
| req_ok | output | 1 | Stream may request an item |
| flag_done | output | 1 | Count-exhausted event flag |
| flag_bus | output | 1 | Bus error event flag |
| flag_burst | output | 1 | Burst mismatch event flag |

## Verification
On every cycle the assertions check the following: run-time locking of reload and configuration, decrement by one, one-shot ending, wrap refill, the stops on bus error and burst mismatch, refusal to start with a flag pending, error priority over the last item, idle behaviour at zero count, and flag stickiness. Only the bench scenarios show that the counts seen at the ports follow the arithmetic over a sweep of item counts in both modes. They also show that restarts reload the previously written value, and that software stop and selective clearing behave as programmed through the register port.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 32;
    localparam int CFG_W  = 6;
    localparam int FLAG_N = 3;

    localparam int RUN_BIT  = 0;
    localparam int WRAP_BIT = 1;
    localparam int CFG_LSB  = 2;

    localparam int FLG_DONE  = 0;
    localparam int FLG_BUS   = 1;
    localparam int FLG_BURST = 2;

    localparam int SEL_LSB = 2;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              ctrl_wr;
        logic              cnt_wr;
        logic              clr_wr;
        logic              run;
        logic              wrap;
        logic [CFG_W-1:0]  cfg;
        logic [CNT_W-1:0]  cnt_val;
        logic [FLAG_N-1:0] clr_mask;
    } wr_cmd_t;

    typedef struct packed {
        logic err;
        logic burst;
        logic item;
        logic last;
    } hw_evt_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input logic run,
                                                   input logic wrap,
                                                   input logic [CFG_W-1:0] cfg);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RUN_BIT] = run;
        w[WRAP_BIT] = wrap;
        w[CFG_LSB +: CFG_W] = cfg;
        return w;
    endfunction
endpackage

// File: rtl/xsc_decode.sv
module xsc_decode
    import xsc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_addr[SEL_LSB +: 2]);

    always_comb begin
        cmd          = '0;
        cmd.run      = wr_data[RUN_BIT];
        cmd.wrap     = wr_data[WRAP_BIT];
        cmd.cfg      = wr_data[CFG_LSB +: CFG_W];
        cmd.cnt_val  = wr_data[CNT_W-1:0];
        cmd.clr_mask = wr_data[FLAG_N-1:0];
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL:  cmd.ctrl_wr = 1'b1;
                SEL_COUNT: cmd.cnt_wr  = 1'b1;
                SEL_CLEAR: cmd.clr_wr  = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/xsc_counter.sv
module xsc_counter
    import xsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            reload <= '0;
        end else if (start) begin
            cnt <= reload;
        end else if (load_wr) begin
            cnt    <= load_val;
            reload <= load_val;
        end else if (step) begin
            cnt <= wrap ? reload : cnt - 1'b1;
        end
    end

    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        step && !wrap && !start && !load_wr |=> cnt == $past(cnt) - 1'b1);

    p_start_reload_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt == $past(reload));
endmodule

// File: rtl/xsc_events.sv
module xsc_events
    import xsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [FLAG_N-1:0] clr_mask,
    output logic [FLAG_N-1:0] flags
);
    logic [FLAG_N-1:0] kill;
    assign kill = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~kill) | set_vec;
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_chk
        p_sticky_r13: assert property (@(posedge clk) disable iff (rst)
            flags[i] && !(clr_wr && clr_mask[i]) |=> flags[i]);
    end
endmodule

// File: rtl/xsc_stream_ctl.sv
module xsc_stream_ctl
    import xsc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              item_done,
    input  logic              bus_err,
    input  logic              burst_mismatch,
    output logic              enabled,
    output logic [CNT_W-1:0]  remaining,
    output logic              req_ok,
    output logic              flag_done,
    output logic              flag_bus,
    output logic              flag_burst
);
    wr_cmd_t           cmd;
    hw_evt_t           ev;
    logic              en_q, wrap_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [CNT_W-1:0]  cnt, reload;
    logic [FLAG_N-1:0] flags, set_vec;
    logic              cnt_nz, any_flag, start, sw_stop, end_hit;

    xsc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd)
    );

    assign cnt_nz   = cnt != '0;
    assign any_flag = |flags;

    always_comb begin
        ev.err   = en_q & bus_err;
        ev.burst = en_q & burst_mismatch;
        ev.item  = en_q & item_done & cnt_nz & ~ev.err & ~ev.burst;
        ev.last  = ev.item & (cnt == CNT_W'(1));
    end

    assign start   = ~en_q & cmd.ctrl_wr & cmd.run & ~any_flag;
    assign sw_stop = en_q & cmd.ctrl_wr & ~cmd.run;
    assign end_hit = ev.last & ~wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            wrap_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            if (en_q) begin
                if (ev.err || ev.burst || end_hit || sw_stop) en_q <= 1'b0;
            end else if (start) begin
                en_q <= 1'b1;
            end
            if (!en_q && cmd.ctrl_wr) begin
                wrap_q <= cmd.wrap;
                cfg_q  <= cmd.cfg;
            end
        end
    end

    xsc_counter u_cnt (
        .clk(clk), .rst(rst), .start(start),
        .load_wr(~en_q & cmd.cnt_wr), .load_val(cmd.cnt_val),
        .step(ev.item), .wrap(ev.last & wrap_q),
        .cnt(cnt), .reload(reload)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_DONE]  = ev.last;
        set_vec[FLG_BUS]   = ev.err;
        set_vec[FLG_BURST] = ev.burst;
    end

    xsc_events u_evt (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_wr(cmd.clr_wr), .clr_mask(cmd.clr_mask), .flags(flags)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_addr[SEL_LSB +: 2]))
            SEL_CTRL:   rd_data = pack_ctrl(en_q, wrap_q, cfg_q);
            SEL_COUNT:  rd_data = DATA_W'(cnt);
            SEL_STATUS: rd_data = DATA_W'(flags);
            default:    rd_data = '0;
        endcase
    end

    assign enabled    = en_q;
    assign remaining  = cnt;
    assign req_ok     = en_q & cnt_nz;
    assign flag_done  = flags[FLG_DONE];
    assign flag_bus   = flags[FLG_BUS];
    assign flag_burst = flags[FLG_BURST];

    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable(reload) && $stable(wrap_q) && $stable(cfg_q));

    p_normal_end_r6: assert property (@(posedge clk) disable iff (rst)
        en_q && !wrap_q && item_done && cnt == CNT_W'(1) && !bus_err && !burst_mismatch
        |=> !en_q && cnt == '0 && flags[FLG_DONE]);

    p_wrap_refill_r7: assert property (@(posedge clk) disable iff (rst)
        en_q && wrap_q && item_done && cnt == CNT_W'(1) && !bus_err && !burst_mismatch && !sw_stop
        |=> en_q && cnt == $past(reload) && flags[FLG_DONE]);

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (rst)
        en_q && !cnt_nz |=> !cnt_nz);

    p_bus_stop_r9: assert property (@(posedge clk) disable iff (rst)
        en_q && bus_err |=> !en_q && flags[FLG_BUS] && $stable(cnt));

    p_burst_stop_r10: assert property (@(posedge clk) disable iff (rst)
        en_q && burst_mismatch |=> !en_q && flags[FLG_BURST]);

    p_refuse_r11: assert property (@(posedge clk) disable iff (rst)
        !en_q && any_flag |=> !en_q);

    p_err_wins_r12: assert property (@(posedge clk) disable iff (rst)
        en_q && bus_err && !flags[FLG_DONE] |=> !flags[FLG_DONE]);
endmodule

// File: tb/sim_xsc_stream_ctl.sv
module sim_xsc_stream_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        item_done = 1'b0, bus_err = 1'b0, burst_mismatch = 1'b0;
    logic        enabled, req_ok, flag_done, flag_bus, flag_burst;
    logic [15:0] remaining;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    xsc_stream_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .item_done(item_done), .bus_err(bus_err),
        .burst_mismatch(burst_mismatch), .enabled(enabled), .remaining(remaining),
        .req_ok(req_ok), .flag_done(flag_done), .flag_bus(flag_bus), .flag_burst(flag_burst)
    );

    localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_STAT = 4'h8, A_CLR = 4'hC;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic i, input logic e, input logic m);
        @(negedge clk);
        item_done = i; bus_err = e; burst_mismatch = m;
        @(negedge clk);
        item_done = 1'b0; bus_err = 1'b0; burst_mismatch = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 enabled", {31'b0, enabled}, 0);
        chk("R1 remaining", {16'b0, remaining}, 0);
        chk("R1 req_ok", {31'b0, req_ok}, 0);
        rd(A_STAT, d); chk("R1 flags", d, 0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);

        // R2 count load and readback with upper bits zero
        wr(A_CNT, 32'hABCD_0007);
        rd(A_CNT, d); chk("R2 count readback", d, 32'h7);
        chk("R2 remaining", {16'b0, remaining}, 7);
        wr(A_CTRL, 32'h0000_00FC);
        rd(A_CTRL, d); chk("R2 cfg write while stopped", d, 32'hFC);

        // R4 start reloads, req_ok; R3 locked writes
        wr(A_CTRL, 32'h1);
        chk("R4 enabled", {31'b0, enabled}, 1);
        chk("R4 req_ok", {31'b0, req_ok}, 1);
        rd(A_CTRL, d); chk("R4 ctrl after start", d, 32'h1);
        wr(A_CNT, 32'd99);
        chk("R3 count write ignored", {16'b0, remaining}, 7);
        wr(A_CTRL, 32'h0000_00FF);
        rd(A_CTRL, d); chk("R3 cfg/wrap write ignored", d, 32'h1);

        // R5 decrement, R14 software stop keeps count
        pulse(1, 0, 0); pulse(1, 0, 0);
        chk("R5 two items", {16'b0, remaining}, 5);
        wr(A_CTRL, 32'h0);
        chk("R14 stopped", {31'b0, enabled}, 0);
        chk("R14 count kept", {16'b0, remaining}, 5);
        rd(A_STAT, d); chk("R14 no flags", d, 0);
        pulse(1, 0, 0);
        chk("R14 item ignored while stopped", {16'b0, remaining}, 5);
        wr(A_CTRL, 32'h1);
        chk("R4 restart reloads", {16'b0, remaining}, 7);
        wr(A_CTRL, 32'h0);

        // R8 zero count blocks service
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h1);
        chk("R8 enabled at zero", {31'b0, enabled}, 1);
        chk("R8 req_ok zero", {31'b0, req_ok}, 0);
        pulse(1, 0, 0);
        chk("R8 count stays", {16'b0, remaining}, 0);
        chk("R8 still enabled", {31'b0, enabled}, 1);
        rd(A_STAT, d); chk("R8 no flag", d, 0);
        wr(A_CTRL, 32'h0);

        // R5/R6 sweep in one-shot mode
        for (int n = 1; n <= 24; n++) begin
            wr(A_CLR, 32'h7);
            wr(A_CNT, n);
            wr(A_CTRL, 32'h1);
            chk("R4 sweep start", {16'b0, remaining}, n);
            for (int k = 1; k <= n; k++) begin
                pulse(1, 0, 0);
                if (k < n) begin
                    chk("R5 sweep count", {16'b0, remaining}, n - k);
                    chk("R5 sweep running", {31'b0, enabled}, 1);
                end else begin
                    chk("R6 end count", {16'b0, remaining}, 0);
                    chk("R6 end stopped", {31'b0, enabled}, 0);
                    chk("R6 done flag", {31'b0, flag_done}, 1);
                    chk("R6 req_ok", {31'b0, req_ok}, 0);
                end
            end
        end

        // R11 refused start while flag pending
        wr(A_CTRL, 32'h1);
        chk("R11 start refused", {31'b0, enabled}, 0);
        wr(A_CLR, 32'h7);
        wr(A_CTRL, 32'h1);
        chk("R11 start after clear", {31'b0, enabled}, 1);
        wr(A_CTRL, 32'h0);

        // R7 wrap sweep
        for (int n = 1; n <= 5; n++) begin
            wr(A_CLR, 32'h7);
            wr(A_CNT, n);
            wr(A_CTRL, 32'h3);
            for (int k = 1; k <= 3 * n; k++) begin
                pulse(1, 0, 0);
                chk("R7 wrap count", {16'b0, remaining}, n - (k % n));
                chk("R7 still running", {31'b0, enabled}, 1);
                chk("R7 wrap flag", {31'b0, flag_done}, (k % n) == 0 ? 1 : 0);
                if (flag_done) wr(A_CLR, 32'h1);
            end
            wr(A_CTRL, 32'h0);
        end

        // R13 selective clear; R10 burst mismatch
        wr(A_CLR, 32'h7);
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h3);
        pulse(1, 0, 0);
        pulse(0, 0, 1);
        chk("R10 burst stop", {31'b0, enabled}, 0);
        rd(A_STAT, d); chk("R10 flags done+burst", d, 32'h5);
        wr(A_CLR, 32'h1);
        rd(A_STAT, d); chk("R13 only done cleared", d, 32'h4);
        wr(A_CLR, 32'h4);
        rd(A_STAT, d); chk("R13 burst cleared", d, 32'h0);

        // R9 bus error mid-run
        wr(A_CNT, 32'd6);
        wr(A_CTRL, 32'h1);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        chk("R9 stopped", {31'b0, enabled}, 0);
        chk("R9 bus flag", {31'b0, flag_bus}, 1);
        chk("R9 count kept", {16'b0, remaining}, 5);
        wr(A_CLR, 32'h7);

        // R12 error with final item
        wr(A_CNT, 32'd1);
        wr(A_CTRL, 32'h1);
        pulse(1, 1, 0);
        chk("R12 stopped", {31'b0, enabled}, 0);
        chk("R12 bus flag", {31'b0, flag_bus}, 1);
        chk("R12 no done flag", {31'b0, flag_done}, 0);
        chk("R12 count not lowered", {16'b0, remaining}, 1);

        finish_run();
    end
endmodule